// File: doc/BRIEF.md
# ATM Cell CRC-10 Inserter

This block sits in the transmit path of a cell-based link and carries 53-byte cells as a byte stream. Each cell is a 5-byte header followed by a 48-byte payload. For each cell, a flag comes in with the cell's first byte. When the flag is set, the block works out a 10-bit cyclic check over the payload. The header is not part of the check. The check covers every payload bit except the last ten: all of the first 46 payload bytes and the top 6 bits of the 47th. The block writes the result into those last ten bits. When the flag is clear, every byte passes through untouched.

On both sides the stream uses valid/ready handshakes and a start-of-cell marker. The output is a single register stage, so each byte leaves one cycle after it is accepted. The input is ready whenever that register is empty or is being drained. As a result, cells can follow each other with no idle bytes between them.

Top module: `atmc_crc10_inserter`

## Requirements
- R1: The five header bytes (cell byte positions 0 to 4) leave the block exactly as they entered, whatever the flag.
- R2: Payload bytes 1 to 46 (cell positions 5 to 50) leave the block unchanged.
- R3: When the flag is 1, the upper six bits [7:2] of payload byte 47 (cell position 51) are unchanged. Its bits [1:0] carry check bits 9 and 8. The check is computed MSB-first over payload bytes 1 to 46 and then bits 7 down to 2 of byte 47, using generator x^10+x^9+x^5+x^4+x+1 (0x233) and a register cleared to zero at the start of each payload, with no final inversion.
- R4: When the flag is 1, payload byte 48 (cell position 52) is replaced by check bits 7 to 0, with bit 7 in the MSB.
- R5: When the flag is 0, all 53 bytes of the cell leave the block unchanged.
- R6: For a cell with insertion, running the same check over all 384 output payload bits leaves a zero remainder.
- R7: The flag is taken only from the byte that carries the start marker. Its value on every other byte of the cell has no effect on the output.
- R8: out_sop is 1 on the first output byte of each cell and 0 on the other 52.
- R9: After reset, out_valid is 0. A byte accepted at the input is presented at the output on the following cycle. While out_valid is 1 and out_ready is 0, the output byte and marker hold steady.
- R10: in_ready is 1 whenever out_ready is 1, so cells sent back to back with the output always ready pass at one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input cell byte |
| in_sop | input | 1 | Input byte is cell position 0 |
| in_crc_en | input | 1 | Insertion flag, taken with the start byte |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output cell byte |
| out_sop | output | 1 | Output byte is cell position 0 |

## Verification
On every cycle, the assertions check the handshake behaviour. Output is held while stalled, each accepted byte appears one cycle later, the input is ready whenever the output is, the valid flag is low after reset, and the start marker lands on every 53rd output byte. The check value itself, the split field across the last two payload bytes and the zero-remainder property can only be seen by comparing whole cells. The same holds for the pass-through of disabled cells and the fact that the flag is ignored off the start byte. The bench's scenarios cover these, including all-zero and all-ones payloads and random stalls on both sides.

// File: rtl/atmc_pkg.sv
package atmc_pkg;

    localparam int BYTE_W    = 8;
    localparam int CHK_W     = 10;
    localparam logic [CHK_W-1:0] CHK_POLY = 10'h233;

    // Positional flags for the byte currently at the input
    typedef struct packed {
        logic start;     // cell position 0
        logic clear;     // first payload byte: check register starts at zero
        logic accum;     // full byte goes into the check
        logic split;     // byte holding the top two check bits
        logic last;      // byte holding the low eight check bits
    } pos_flags_t;

    typedef struct packed {
        logic              sop;
        logic [BYTE_W-1:0] data;
    } out_beat_t;

    // One MSB-first bit step of the check register
    function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] r,
                                                   input logic b);
        logic fb;
        fb = r[CHK_W-1] ^ b;
        return {r[CHK_W-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
    endfunction

    // Feed the top nbits of a byte, MSB first
    function automatic logic [CHK_W-1:0] chk_byte(input logic [CHK_W-1:0] r,
                                                   input logic [BYTE_W-1:0] d,
                                                   input int nbits);
        logic [CHK_W-1:0] acc;
        acc = r;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < nbits) acc = chk_step(acc, d[BYTE_W-1-i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/atmc_cell_tracker.sv
module atmc_cell_tracker
    import atmc_pkg::*;
#(
    parameter int HDR_BYTES = 5,
    parameter int PAY_BYTES = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       sop,
    input  logic       flag,
    output pos_flags_t pos,
    output logic       cell_en
);
    localparam int CELL_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int CNT_W      = $clog2(CELL_BYTES);
    localparam logic [CNT_W-1:0] IDX_CLEAR = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] IDX_SPLIT = CNT_W'(CELL_BYTES - 2);
    localparam logic [CNT_W-1:0] IDX_LAST  = CNT_W'(CELL_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic             en_q;

    assign idx     = sop ? '0 : cnt_q;
    assign cell_en = sop ? flag : en_q;

    always_comb begin
        pos.start = (idx == '0);
        pos.clear = (idx == IDX_CLEAR);
        pos.accum = (idx >= IDX_CLEAR) && (idx < IDX_SPLIT);
        pos.split = (idx == IDX_SPLIT);
        pos.last  = (idx == IDX_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (take) begin
            cnt_q <= pos.last ? '0 : idx + 1'b1;
            if (sop) en_q <= flag;
        end
    end

endmodule

// File: rtl/atmc_crc10_acc.sv
module atmc_crc10_acc
    import atmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  pos_flags_t        pos,
    input  logic [BYTE_W-1:0] data,
    output logic [CHK_W-1:0]  chk_split,
    output logic [CHK_W-1:0]  chk_q
);
    logic [CHK_W-1:0] base;
    logic [CHK_W-1:0] chk_full;

    assign base      = pos.clear ? '0 : chk_q;
    assign chk_full  = chk_byte(base, data, BYTE_W);
    assign chk_split = chk_byte(base, data, BYTE_W - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q <= '0;
        end else if (take) begin
            if (pos.accum)      chk_q <= chk_full;
            else if (pos.split) chk_q <= chk_split;
        end
    end

endmodule

// File: rtl/atmc_out_stage.sv
module atmc_out_stage
    import atmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  out_beat_t         beat,
    output logic              can_load,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop
);
    out_beat_t beat_q;
    logic      vld_q;

    assign can_load  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = beat_q.data;
    assign out_sop   = beat_q.sop;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            beat_q <= '0;
        end else if (load) begin
            vld_q  <= 1'b1;
            beat_q <= beat;
        end else if (out_ready) begin
            vld_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/atmc_crc10_inserter.sv
module atmc_crc10_inserter
    import atmc_pkg::*;
#(
    parameter int HDR_BYTES = 5,
    parameter int PAY_BYTES = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_crc_en,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sop
);
    pos_flags_t       pos;
    logic             cell_en;
    logic             take;
    logic [CHK_W-1:0] chk_split;
    logic [CHK_W-1:0] chk_q;
    out_beat_t        beat;

    assign take = in_valid && in_ready;

    atmc_cell_tracker #(
        .HDR_BYTES(HDR_BYTES),
        .PAY_BYTES(PAY_BYTES)
    ) trk_i (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .sop     (in_sop),
        .flag    (in_crc_en),
        .pos     (pos),
        .cell_en (cell_en)
    );

    atmc_crc10_acc acc_i (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .pos       (pos),
        .data      (in_data),
        .chk_split (chk_split),
        .chk_q     (chk_q)
    );

    always_comb begin
        beat.sop  = pos.start;
        beat.data = in_data;
        if (cell_en && pos.split)
            beat.data = {in_data[7:2], chk_split[CHK_W-1 -: 2]};
        else if (cell_en && pos.last)
            beat.data = chk_q[BYTE_W-1:0];
    end

    atmc_out_stage out_i (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .beat      (beat),
        .can_load  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop)
    );

endmodule

// File: rtl/atmc_crc10_checker.sv
module atmc_crc10_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_sop
);
    logic [5:0] ocnt_q;

    always_ff @(posedge clk) begin
        if (rst) ocnt_q <= '0;
        else if (out_valid && out_ready) ocnt_q <= (ocnt_q == 6'd52) ? '0 : ocnt_q + 1'b1;
    end

    a_r9_reset_idle: assert property (@(posedge clk) $fell(rst) |-> !out_valid);

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)));

    a_r10_ready: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    a_r8_sop_spacing: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sop == (ocnt_q == 6'd0)));

endmodule

bind atmc_crc10_inserter atmc_crc10_checker chk_i (.*);

// File: tb/atmc_crc10_inserter_tb.sv
module atmc_crc10_inserter_tb_top;
    localparam int CLK_P   = 10;
    localparam int NCELL   = 40;
    localparam int CB      = 53;
    localparam int NBYTE   = NCELL * CB;
    localparam int PHASE_A = 8;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_sop, in_crc_en;
    logic [7:0] in_data;
    logic out_valid, out_ready, out_sop;
    logic [7:0] out_data;

    always #(CLK_P/2) clk = ~clk;

    atmc_crc10_inserter dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_crc_en(in_crc_en),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop)
    );

    logic [7:0] stim [NBYTE];
    logic       noise_en [NBYTE];
    logic       cell_flag [NCELL];
    logic [7:0] got [NBYTE];
    logic       got_sop [NBYTE];

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] ref_step(input logic [9:0] r, input logic b);
        logic fb;
        fb = r[9] ^ b;
        return {r[8:0], 1'b0} ^ (fb ? 10'h233 : 10'h000);
    endfunction

    // Check over the first nbits of the payload of cell c held in stim or got
    function automatic logic [9:0] ref_chk(input int c, input int nbits, input bit use_got);
        logic [9:0] r = '0;
        for (int i = 0; i < nbits; i++) begin
            logic [7:0] b;
            b = use_got ? got[c*CB + 5 + i/8] : stim[c*CB + 5 + i/8];
            r = ref_step(r, b[7 - i%8]);
        end
        return r;
    endfunction

    initial begin
        int ip, op, cyc, stalls_a, first_in, first_out, sop_err;
        bit done_a;
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < NCELL; c++) begin
            cell_flag[c] = (c == 2 || c == 3) ? 1'b0 : (c < 2 ? 1'b1 : 1'($urandom));
            for (int k = 0; k < CB; k++) begin
                logic [7:0] v;
                v = 8'($urandom);
                if (k >= 5 && c == 0) v = 8'h00;
                if (k >= 5 && (c == 1 || c == 3)) v = 8'hFF;
                stim[c*CB + k] = v;
                noise_en[c*CB + k] = 1'($urandom);
            end
        end
        in_valid = 0; in_data = 0; in_sop = 0; in_crc_en = 0; out_ready = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R9", "out_valid after reset", int'(out_valid), 0);

        ip = 0; op = 0; cyc = 0; stalls_a = 0; first_in = -1; first_out = -1; sop_err = 0; done_a = 0;
        while (op < NBYTE && cyc < 20000) begin
            bit phase_a;
            phase_a = (ip < PHASE_A*CB) || (op < PHASE_A*CB);
            @(negedge clk);
            if (ip < NBYTE) begin
                in_valid  = phase_a ? 1'b1 : 1'(($urandom % 4) != 0);
                in_data   = stim[ip];
                in_sop    = (ip % CB == 0);
                // R7: flag on non-start bytes is random noise
                in_crc_en = in_sop ? cell_flag[ip / CB] : noise_en[ip];
            end else begin
                in_valid = 1'b0;
            end
            out_ready = phase_a ? 1'b1 : 1'(($urandom % 3) != 0);
            #(CLK_P/2 - 1);
            if (phase_a && in_valid && !in_ready) stalls_a++;
            if (out_valid && out_ready) begin
                if (first_out < 0) first_out = cyc;
                got[op] = out_data;
                got_sop[op] = out_sop;
                if (out_sop != (op % CB == 0)) sop_err++;
                op++;
            end
            if (in_valid && in_ready) begin
                if (first_in < 0) first_in = cyc;
                ip++;
            end
            cyc++;
        end
        if (cyc >= 20000) check("R9", "watchdog expired bytes_out", op, NBYTE);

        check("R9", "first output one cycle after first input", first_out - first_in, 1);
        check("R10", "input stalls with output always ready", stalls_a, 0);
        check("R8", "start marker placement errors", sop_err, 0);

        for (int c = 0; c < NCELL; c++) begin
            int hdr_bad, body_bad, all_bad;
            logic [9:0] e;
            hdr_bad = 0; body_bad = 0; all_bad = 0;
            for (int k = 0; k < CB; k++) begin
                if (got[c*CB+k] != stim[c*CB+k]) begin
                    all_bad++;
                    if (k < 5) hdr_bad++;
                    else if (k < 51) body_bad++;
                end
            end
            check("R1", $sformatf("cell %0d header mismatches", c), hdr_bad, 0);
            check("R2", $sformatf("cell %0d payload mismatches", c), body_bad, 0);
            if (cell_flag[c]) begin
                e = ref_chk(c, 374, 1'b0);
                // R3 / R7: flag from start byte only
                check("R3", $sformatf("cell %0d split byte", c), int'(got[c*CB+51]),
                      int'({stim[c*CB+51][7:2], e[9:8]}));
                check("R4", $sformatf("cell %0d last byte", c), int'(got[c*CB+52]), int'(e[7:0]));
                check("R6", $sformatf("cell %0d residue", c), int'(ref_chk(c, 384, 1'b1)), 0);
            end else begin
                check("R5", $sformatf("cell %0d pass-through mismatches (R7)", c), all_bad, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule